// File: doc/BRIEF.md
# Multi-Queue Receive Error Handler

This block sits beside the DMA path of a packet receiver that serves several receive queues. At the end of each frame the receiver gives it a one-cycle report: the queue the frame belonged to, and whether the frame had a checksum (CRC) mismatch or met a system-bus fault during its DMA transfer. The block turns that report into actions. It can write the buffer descriptor status, send a restart-search pulse to the frame aligner, set sticky event bits, count discarded frames, and set per-queue halt bits.

A checksum failure closes the current buffer with its CRC flag set. It raises the receive-frame event of that queue and sends the aligner back to searching for a frame start. A bus fault drops the frame and raises the bus-fault event. It also adds one to a saturating discard counter and halts only the affected queue, so the other queues keep running. A report for a halted queue is dropped silently: no descriptor is touched and nothing is counted. The queue runs again once software writes a one to its halt bit.

The controller is a four-state machine, with every state lasting one cycle. IDLE means no action. CHECKSUM closes the descriptor and restarts the search. BUSFAULT discards, counts and halts. DROP drops a frame for a halted queue. From every state the next state is chosen from the report present in that cycle. No report leads to IDLE. A report for a halted queue leads to DROP. A report with a bus fault leads to BUSFAULT. A report with only a checksum failure leads to CHECKSUM. A clean report leads to IDLE. A queue that is in the BUSFAULT state counts as already halted.

Top module: `rx_err_handler`

## Requirements
- R1: One cycle after a report with only a checksum failure for a running queue q, `bd_wr_o`, `bd_crc_o` and `bd_close_o` are high for one cycle and `bd_q_o` equals q.
- R2: In that same cycle `hunt_o` pulses high. It is low in every other cycle.
- R3: A checksum-failure action sets event bit q (bits 0..NQ-1 of `events_o` are the per-queue receive-frame events).
- R4: A bus-fault action sets event bit NQ of `events_o` and writes no descriptor.
- R5: Each bus-fault action adds one to `disc_cnt_o`. At its maximum value the counter holds.
- R6: A bus-fault action sets only the halt bit of the reporting queue. The other halt bits are unchanged.
- R7: A report for a halted queue produces a one-cycle `drop_o` pulse. It writes no descriptor, sets no event, counts nothing and changes no halt bit. This includes a report in the cycle right after a bus fault on the same queue.
- R8: Writing a one to bit q of `halt_clr_i` clears halt bit q, and later reports for queue q are handled again.
- R9: Event bits stay set until a one is written to the same bit of `ev_clr_i`. A set and a clear in the same cycle leave the bit set.
- R10: A report with both a checksum failure and a bus fault is handled as a bus fault only.
- R11: After reset, all events, halt bits, the counter and all pulse outputs are zero.
- R12: A report with neither error on a running queue changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_vld_i | input | 1 | End-of-frame report strobe |
| frm_q_i | input | QW | Queue index of the report |
| frm_crc_i | input | 1 | Checksum mismatch in the frame |
| frm_bus_i | input | 1 | System-bus fault during the frame's DMA |
| ev_clr_i | input | NQ+1 | Write-one-to-clear for the event bits |
| halt_clr_i | input | NQ | Write-one-to-clear for the halt bits |
| bd_wr_o | output | 1 | Descriptor status write strobe |
| bd_crc_o | output | 1 | CRC flag value for the descriptor |
| bd_close_o | output | 1 | Close the current buffer |
| bd_q_o | output | QW | Queue of the descriptor write |
| hunt_o | output | 1 | Restart the frame-start search |
| drop_o | output | 1 | Report dropped because its queue is halted |
| events_o | output | NQ+1 | Sticky events: per-queue receive-frame bits, then bus fault |
| halt_o | output | NQ | Per-queue halt bits |
| disc_cnt_o | output | CNT_W | Saturating discarded-frame counter |

## Verification
The bench builds the block with four queues and a 3-bit discard counter. With seven bus faults the counter reaches its ceiling, so one further fault shows that it saturates, without a run of sixty-five thousand frames. Four queues are enough to show that a halt is isolated to one queue while the others keep running. They also cover the back-to-back case, where a report arrives while its queue is still in the BUSFAULT state.

// File: rtl/rxerr_pkg.sv
package rxerr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_CHECKSUM = 2'd1,
        ST_BUSFAULT = 2'd2,
        ST_DROP     = 2'd3
    } rxerr_state_e;
endpackage

// File: rtl/rxerr_sticky.sv
module rxerr_sticky #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] val_o
);
    logic [W-1:0] val_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= (val_q & ~clr_i) | set_i;
    end

    assign val_o = val_q;

    // R9
    set_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((val_o & $past(set_i)) == $past(set_i)));
    // R9
    clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((val_o & $past(clr_i) & ~$past(set_i)) == '0));
endmodule

// File: rtl/rxerr_satcnt.sv
module rxerr_satcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] MAX = '1;
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (inc_i && cnt_q != MAX)  cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && cnt_o != MAX) |=> (cnt_o == $past(cnt_o) + 1'b1));
    // R5
    count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == MAX) |=> (cnt_o == MAX));
endmodule

// File: rtl/rxerr_fsm.sv
module rxerr_fsm
    import rxerr_pkg::*;
#(
    parameter int NQ = 4,
    parameter int QW = $clog2(NQ)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frm_vld_i,
    input  logic [QW-1:0] frm_q_i,
    input  logic          frm_crc_i,
    input  logic          frm_bus_i,
    input  logic [NQ-1:0] halt_i,
    output logic [QW-1:0] q_o,
    output logic          bd_wr_o,
    output logic          hunt_o,
    output logic          drop_o,
    output logic [NQ-1:0] rxf_set_o,
    output logic          bus_set_o,
    output logic [NQ-1:0] halt_set_o,
    output logic          cnt_inc_o
);
    rxerr_state_e state_q, state_d;
    logic [QW-1:0] q_r;
    logic [NQ-1:0] q_onehot;
    logic [NQ-1:0] halt_eff;

    assign q_onehot = NQ'(1) << q_r;
    // a queue in BUSFAULT this cycle counts as halted already
    assign halt_eff = halt_i | ((state_q == ST_BUSFAULT) ? q_onehot : '0);

    always_comb begin
        state_d = ST_IDLE;
        if (frm_vld_i) begin
            if (halt_eff[frm_q_i])  state_d = ST_DROP;
            else if (frm_bus_i)     state_d = ST_BUSFAULT;
            else if (frm_crc_i)     state_d = ST_CHECKSUM;
            else                    state_d = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            q_r     <= '0;
        end else begin
            state_q <= state_d;
            if (frm_vld_i) q_r <= frm_q_i;
        end
    end

    always_comb begin
        bd_wr_o    = 1'b0;
        hunt_o     = 1'b0;
        drop_o     = 1'b0;
        rxf_set_o  = '0;
        bus_set_o  = 1'b0;
        halt_set_o = '0;
        cnt_inc_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_CHECKSUM: begin
                bd_wr_o   = 1'b1;
                hunt_o    = 1'b1;
                rxf_set_o = q_onehot;
            end
            ST_BUSFAULT: begin
                bus_set_o  = 1'b1;
                halt_set_o = q_onehot;
                cnt_inc_o  = 1'b1;
            end
            ST_DROP: drop_o = 1'b1;
            default: ;
        endcase
    end

    assign q_o = q_r;

    // R1
    crc_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld_i && frm_crc_i && !frm_bus_i && !halt_i[frm_q_i]
         && !(state_q == ST_BUSFAULT && q_r == frm_q_i))
        |=> (bd_wr_o && q_o == $past(frm_q_i)));
    // R7
    halted_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld_i && halt_i[frm_q_i]) |=> (drop_o && !bd_wr_o && !cnt_inc_o));
    // R10
    bus_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld_i && frm_bus_i && frm_crc_i && !halt_i[frm_q_i]) |=> !bd_wr_o);
    // R12
    clean_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld_i && !frm_bus_i && !frm_crc_i) |=> (!bd_wr_o && !cnt_inc_o && !hunt_o));
endmodule

// File: rtl/rx_err_handler.sv
module rx_err_handler #(
    parameter int NQ    = 4,
    parameter int CNT_W = 16,
    parameter int QW    = $clog2(NQ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_vld_i,
    input  logic [QW-1:0]    frm_q_i,
    input  logic             frm_crc_i,
    input  logic             frm_bus_i,
    input  logic [NQ:0]      ev_clr_i,
    input  logic [NQ-1:0]    halt_clr_i,
    output logic             bd_wr_o,
    output logic             bd_crc_o,
    output logic             bd_close_o,
    output logic [QW-1:0]    bd_q_o,
    output logic             hunt_o,
    output logic             drop_o,
    output logic [NQ:0]      events_o,
    output logic [NQ-1:0]    halt_o,
    output logic [CNT_W-1:0] disc_cnt_o
);
    localparam int EV_W = NQ + 1;

    logic [NQ-1:0] rxf_set, halt_set;
    logic          bus_set, cnt_inc, bd_wr;

    rxerr_fsm #(.NQ(NQ), .QW(QW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .frm_vld_i  (frm_vld_i),
        .frm_q_i    (frm_q_i),
        .frm_crc_i  (frm_crc_i),
        .frm_bus_i  (frm_bus_i),
        .halt_i     (halt_o),
        .q_o        (bd_q_o),
        .bd_wr_o    (bd_wr),
        .hunt_o     (hunt_o),
        .drop_o     (drop_o),
        .rxf_set_o  (rxf_set),
        .bus_set_o  (bus_set),
        .halt_set_o (halt_set),
        .cnt_inc_o  (cnt_inc)
    );

    rxerr_sticky #(.W(EV_W)) u_events (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i ({bus_set, rxf_set}),
        .clr_i (ev_clr_i),
        .val_o (events_o)
    );

    rxerr_sticky #(.W(NQ)) u_halts (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (halt_set),
        .clr_i (halt_clr_i),
        .val_o (halt_o)
    );

    rxerr_satcnt #(.W(CNT_W)) u_disc (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (cnt_inc),
        .cnt_o (disc_cnt_o)
    );

    assign bd_wr_o    = bd_wr;
    assign bd_crc_o   = bd_wr;
    assign bd_close_o = bd_wr;

    // R6
    one_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(halt_o & ~$past(halt_o)));
    // R4
    bus_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disc_cnt_o != $past(disc_cnt_o)) |-> events_o[NQ]);
    // R2
    hunt_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hunt_o |-> (bd_wr_o && !drop_o));
endmodule

// File: tb/rx_err_handler_test.sv
`timescale 1ns/1ps
module rx_err_handler_test;
    localparam int NQ = 4;
    localparam int CW = 3;
    localparam int QW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frm_vld = 1'b0, frm_crc = 1'b0, frm_bus = 1'b0;
    logic [QW-1:0] frm_q = '0;
    logic [NQ:0] ev_clr = '0;
    logic [NQ-1:0] halt_clr = '0;
    logic bd_wr, bd_crc, bd_close, hunt, drop;
    logic [QW-1:0] bd_q;
    logic [NQ:0] events;
    logic [NQ-1:0] halt;
    logic [CW-1:0] cnt;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic p_wr, p_crc, p_close, p_hunt, p_drop;
    logic [QW-1:0] p_q;

    always #2 clk = ~clk;

    rx_err_handler #(.NQ(NQ), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .frm_vld_i(frm_vld), .frm_q_i(frm_q),
        .frm_crc_i(frm_crc), .frm_bus_i(frm_bus), .ev_clr_i(ev_clr),
        .halt_clr_i(halt_clr), .bd_wr_o(bd_wr), .bd_crc_o(bd_crc),
        .bd_close_o(bd_close), .bd_q_o(bd_q), .hunt_o(hunt), .drop_o(drop),
        .events_o(events), .halt_o(halt), .disc_cnt_o(cnt)
    );

    typedef struct packed {
        logic [1:0] q;
        logic       crc;
        logic       bus;
        logic       wr;
        logic       drp;
        logic [4:0] ev;
        logic [3:0] hl;
        logic [2:0] cn;
    } vec_t;

    localparam vec_t TBL [7] = '{
        '{2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 5'b00001, 4'b0000, 3'd0}, // R1 R3
        '{2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00001, 4'b0000, 3'd0}, // R12
        '{2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 5'b10001, 4'b0100, 3'd1}, // R4 R6
        '{2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 5'b10001, 4'b0100, 3'd1}, // R7
        '{2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 5'b10001, 4'b1100, 3'd2}, // R10
        '{2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 5'b10011, 4'b1100, 3'd2}, // R3
        '{2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 5'b10011, 4'b1100, 3'd2}  // R7
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // entered at a falling edge; returns one falling edge after the state registers settle
    task automatic send(input logic [QW-1:0] q, input logic c, input logic b);
        frm_vld = 1'b1; frm_q = q; frm_crc = c; frm_bus = b;
        @(negedge clk);
        p_wr = bd_wr; p_crc = bd_crc; p_close = bd_close; p_hunt = hunt;
        p_drop = drop; p_q = bd_q;
        frm_vld = 1'b0; frm_crc = 1'b0; frm_bus = 1'b0;
        @(negedge clk);
    endtask

    task automatic hclear(input logic [NQ-1:0] m);
        halt_clr = m;
        @(negedge clk);
        halt_clr = '0;
        @(negedge clk);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 events", 32'(events), 0);
        chk("R11 halt", 32'(halt), 0);
        chk("R11 count", 32'(cnt), 0);
        chk("R11 pulses", 32'({bd_wr, hunt, drop}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 7; i++) begin
            send(TBL[i].q, TBL[i].crc, TBL[i].bus);
            chk("R1 bd_wr", 32'(p_wr), 32'(TBL[i].wr));
            chk("R2 hunt", 32'(p_hunt), 32'(TBL[i].wr));
            chk("R7 drop", 32'(p_drop), 32'(TBL[i].drp));
            if (TBL[i].wr) begin
                chk("R1 crc+close", 32'({p_crc, p_close}), 32'(2'b11));
                chk("R1 queue", 32'(p_q), 32'(TBL[i].q));
            end
            chk("R9 events", 32'(events), 32'(TBL[i].ev));
            chk("R6 halt", 32'(halt), 32'(TBL[i].hl));
            chk("R5 count", 32'(cnt), 32'(TBL[i].cn));
        end

        // R8 clear halt of queue 2 and resume it
        hclear(4'b0100);
        chk("R8 halt cleared", 32'(halt), 32'(4'b1000));
        send(2'd2, 1'b1, 1'b0);
        chk("R8 resumed write", 32'(p_wr), 1);
        chk("R8 event", 32'(events), 32'(5'b10111));

        // R9 write-one-to-clear
        ev_clr = 5'b10001;
        @(negedge clk);
        ev_clr = '0;
        @(negedge clk);
        chk("R9 w1c", 32'(events), 32'(5'b00110));

        // R7 back-to-back: bus fault then checksum on queue 0 the next cycle
        frm_vld = 1'b1; frm_q = 2'd0; frm_bus = 1'b1; frm_crc = 1'b0;
        @(negedge clk);
        frm_bus = 1'b0; frm_crc = 1'b1;
        @(negedge clk);
        chk("R7 back-to-back drop", 32'(drop), 1);
        chk("R7 back-to-back no write", 32'(bd_wr), 0);
        frm_vld = 1'b0; frm_crc = 1'b0;
        @(negedge clk);
        chk("R7 count once", 32'(cnt), 3);
        chk("R6 halt q0", 32'(halt), 32'(4'b1001));
        chk("R7 no rxf event", 32'(events), 32'(5'b10110));

        // R9 set wins over clear in the same cycle
        frm_vld = 1'b1; frm_q = 2'd3; frm_crc = 1'b1;
        hclear(4'b1000);
        frm_vld = 1'b1; frm_q = 2'd3; frm_crc = 1'b1;
        @(negedge clk);
        frm_vld = 1'b0; frm_crc = 1'b0;
        ev_clr = 5'b01000;
        @(negedge clk);
        ev_clr = '0;
        chk("R9 set wins", 32'(events[3]), 1);

        // R5 saturation
        hclear(4'b1111);
        for (int q = 0; q < 4; q++) send(2'(q), 1'b0, 1'b1);
        chk("R5 reach max", 32'(cnt), 7);
        chk("R6 all halted", 32'(halt), 32'(4'b1111));
        hclear(4'b1111);
        send(2'd0, 1'b0, 1'b1);
        chk("R5 saturated", 32'(cnt), 7);
        chk("R6 only q0", 32'(halt), 32'(4'b0001));
        chk("R4 bus event", 32'(events[4]), 1);

        // R11 reset again
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 reset all", 32'({events, halt, cnt}), 0);

        done = 1;
        summary();
    end
endmodule